// File: doc/BRIEF.md
# Memory Test Address Generator

This block feeds a memory traffic tester with a stream of addresses. It holds one current address, kept as a 31-bit symbol address. On every accepted transaction it steps that address according to one of four modes: plain sequential, sequential with a rewind to the start address on every loop, fully random, or a hybrid. In the hybrid mode a low field counts in steps while the bits above it take a fresh random value only on every second address. Random values come from a built-in 32-bit Galois LFSR, which is seeded on reset.

The tester drives a next strobe together with the downstream ready signal, and a loop-restart strobe at the top of each loop. Each new address is presented both as a 26-bit word address and as the matching symbol address. A symbol word holds 32 symbols, and the word address is forced to the burst alignment. The start address, increment, mode, field index, burst alignment and seed come in as static configuration inputs.

Top module: `mtag_addr_gen`

## Requirements
- R1: During reset and on the first cycle after it, both `addr_word_o` and `addr_sym_o` read zero.
- R2: Mode codes are 0 sequential, 1 random, 2 sequential-with-rewind and 3 random-sequential. In modes 0 and 2 an accepted step sets the internal symbol address to its previous value plus `cfg_incr`, modulo 2^31.
- R3: A step is accepted only when `nxt_req` and `nxt_rdy` are both 1. Without an accepted step or a `loop_start`, the outputs hold their value.
- R4: In mode 1 an accepted step loads bits 30:0 of the current LFSR state as the new symbol address, and then advances the LFSR once. The LFSR shifts right each advance. When the bit shifted out is 1, the state is XORed with 0x80200003.
- R5: In mode 3 the low field, which is symbol bits `cfg_field_msb`:0 (the whole address when the index is 30 or more), becomes (old address + `cfg_incr`) masked to that field. It wraps without carrying into the bits above.
- R6: In mode 3 a one-bit phase alternates on each accepted step and is cleared by `loop_start`. On a step with phase 0 the bits above the field are held. On a step with phase 1 they take the matching bits of the LFSR state, and the LFSR advances.
- R7: `loop_start` loads `cfg_start_addr` into the address if it is the first `loop_start` since reset, or if the mode is 2. Otherwise it leaves the address unchanged.
- R8: `addr_word_o` is symbol address bits 30:5 with alignment applied. `addr_sym_o` equals `addr_word_o` shifted left by 5. Both are registered and update in the cycle after a `loop_start` or an accepted step.
- R9: The low `cfg_burst_log2` bits of `addr_word_o` are forced to zero.
- R10: Reset loads `cfg_seed` into the LFSR. A zero seed is replaced by 0x5EEDC0DE.
- R11: `loop_start` takes priority over a step in the same cycle. The address does not advance and the LFSR does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Address mode code |
| cfg_start_addr | input | 31 | Start symbol address |
| cfg_incr | input | 31 | Symbol address increment |
| cfg_field_msb | input | 5 | Top bit index of the sequential field in mode 3 |
| cfg_burst_log2 | input | 3 | log2 of burst length in words, for alignment |
| cfg_seed | input | 32 | LFSR seed taken at reset |
| nxt_req | input | 1 | Request for the next address |
| nxt_rdy | input | 1 | Downstream ready; qualifies nxt_req |
| loop_start | input | 1 | Start of a loop iteration |
| addr_word_o | output | 26 | Aligned word address |
| addr_sym_o | output | 31 | Aligned symbol address |

## Verification
The hardest case to reach is the random-sequential mode. There, correctness depends on the hidden phase bit and on exactly how far the LFSR has moved since reset. The bench therefore first drives the generator through sequential, rewind and random stretches that consume known numbers of LFSR steps. It then issues a `loop_start` to clear the phase, and runs a long run of steps with a 9-bit field. An increment of 0xC0 (6 words) makes the field wrap several times. The same stretch also puts a `loop_start` and a step in the same cycle, which shows whether the phase and the LFSR moved. A second reset with a zero seed then reaches the substitute seed.

// File: rtl/mtag_pkg.sv
package mtag_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ      = 2'd0,
        MODE_RAND     = 2'd1,
        MODE_SEQ_RET  = 2'd2,
        MODE_RSEQ     = 2'd3
    } addr_mode_e;

    localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;
    localparam logic [31:0] LFSR_ALT_SEED = 32'h5EED_C0DE;

endpackage

// File: rtl/mtag_lfsr.sv
module mtag_lfsr #(
    parameter int          W        = 32,
    parameter logic [W-1:0] TAPS     = W'(32'h8020_0003),
    parameter logic [W-1:0] ALT_SEED = W'(32'h5EED_C0DE)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = state_q >> 1;
            if (state_q[0]) state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= (seed == '0) ? ALT_SEED : seed;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/mtag_next_addr.sv
module mtag_next_addr
    import mtag_pkg::*;
#(
    parameter int AW  = 31,
    parameter int FIW = $clog2(AW)
) (
    input  addr_mode_e      mode,
    input  logic [AW-1:0]   cur,
    input  logic [AW-1:0]   incr,
    input  logic [AW-1:0]   start,
    input  logic [FIW-1:0]  field_msb,
    input  logic [AW-1:0]   rnd,
    input  logic            phase,
    input  logic            started,
    input  logic            loop_start,
    input  logic            adv,
    output logic [AW-1:0]   cur_nxt,
    output logic            phase_nxt,
    output logic            upd,
    output logic            take_rnd
);

    logic [AW-1:0] sum;
    logic [AW-1:0] fmask;

    always_comb begin
        sum = cur + incr;
        if (field_msb >= FIW'(AW - 1)) fmask = '1;
        else fmask = (AW'(1) << (field_msb + 1'b1)) - AW'(1);
    end

    always_comb begin
        cur_nxt   = cur;
        phase_nxt = phase;
        upd       = 1'b0;
        take_rnd  = 1'b0;
        if (loop_start) begin
            upd       = 1'b1;
            phase_nxt = 1'b0;
            if (!started || mode == MODE_SEQ_RET) cur_nxt = start;
        end else if (adv) begin
            upd = 1'b1;
            unique case (mode)
                MODE_SEQ, MODE_SEQ_RET: cur_nxt = sum;
                MODE_RAND: begin
                    cur_nxt  = rnd;
                    take_rnd = 1'b1;
                end
                MODE_RSEQ: begin
                    phase_nxt = ~phase;
                    if (phase) begin
                        cur_nxt  = (rnd & ~fmask) | (sum & fmask);
                        take_rnd = 1'b1;
                    end else begin
                        cur_nxt  = (cur & ~fmask) | (sum & fmask);
                    end
                end
                default: cur_nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/mtag_word_conv.sv
module mtag_word_conv #(
    parameter int AW    = 31,
    parameter int SHIFT = 5,
    parameter int BLW   = 3,
    localparam int WAW  = AW - SHIFT
) (
    input  logic [AW-1:0]  sym,
    input  logic [BLW-1:0] burst_log2,
    output logic [WAW-1:0] word
);

    logic [WAW-1:0] amask;

    always_comb begin
        amask = (WAW'(1) << burst_log2) - WAW'(1);
        word  = sym[AW-1:SHIFT] & ~amask;
    end

endmodule

// File: rtl/mtag_addr_gen.sv
module mtag_addr_gen
    import mtag_pkg::*;
#(
    parameter int AW     = 31,
    parameter int SHIFT  = 5,
    parameter int LW     = 32,
    parameter int BLW    = 3,
    localparam int WAW   = AW - SHIFT,
    localparam int FIW   = $clog2(AW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_mode,
    input  logic [AW-1:0]   cfg_start_addr,
    input  logic [AW-1:0]   cfg_incr,
    input  logic [FIW-1:0]  cfg_field_msb,
    input  logic [BLW-1:0]  cfg_burst_log2,
    input  logic [LW-1:0]   cfg_seed,
    input  logic            nxt_req,
    input  logic            nxt_rdy,
    input  logic            loop_start,
    output logic [WAW-1:0]  addr_word_o,
    output logic [AW-1:0]   addr_sym_o
);

    typedef struct packed {
        logic [AW-1:0]  cur;
        logic [WAW-1:0] word;
        logic           phase;
        logic           started;
    } gen_st_t;

    gen_st_t st_d, st_q;

    addr_mode_e     mode;
    logic           adv;
    logic [LW-1:0]  lfsr_q;
    logic [AW-1:0]  cur_nxt;
    logic           phase_nxt, upd, take_rnd;
    logic [WAW-1:0] word_nxt;

    assign mode = addr_mode_e'(cfg_mode);
    assign adv  = nxt_req & nxt_rdy;

    mtag_lfsr #(
        .W(LW), .TAPS(LW'(LFSR_TAPS)), .ALT_SEED(LW'(LFSR_ALT_SEED))
    ) lfsr_i (
        .clk(clk), .rst_n(rst_n), .seed(cfg_seed),
        .step(take_rnd), .state(lfsr_q)
    );

    mtag_next_addr #(.AW(AW), .FIW(FIW)) nxt_i (
        .mode(mode), .cur(st_q.cur), .incr(cfg_incr), .start(cfg_start_addr),
        .field_msb(cfg_field_msb), .rnd(lfsr_q[AW-1:0]), .phase(st_q.phase),
        .started(st_q.started), .loop_start(loop_start), .adv(adv),
        .cur_nxt(cur_nxt), .phase_nxt(phase_nxt), .upd(upd), .take_rnd(take_rnd)
    );

    mtag_word_conv #(.AW(AW), .SHIFT(SHIFT), .BLW(BLW)) conv_i (
        .sym(cur_nxt), .burst_log2(cfg_burst_log2), .word(word_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.cur   = cur_nxt;
            st_d.word  = word_nxt;
            st_d.phase = phase_nxt;
        end
        if (loop_start) st_d.started = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_word_o = st_q.word;
    assign addr_sym_o  = {st_q.word, {SHIFT{1'b0}}};

endmodule

// File: rtl/mtag_addr_gen_chk.sv
module mtag_addr_gen_chk
    import mtag_pkg::*;
#(
    parameter int AW  = 31,
    parameter int WAW = 26,
    parameter int LW  = 32,
    parameter int BLW = 3,
    parameter int FIW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     cfg_mode,
    input logic [AW-1:0]  cfg_start_addr,
    input logic [AW-1:0]  cfg_incr,
    input logic [FIW-1:0] cfg_field_msb,
    input logic [BLW-1:0] cfg_burst_log2,
    input logic           nxt_req,
    input logic           nxt_rdy,
    input logic           loop_start,
    input logic [WAW-1:0] addr_word_o,
    input logic [AW-1:0]  cur_q,
    input logic           phase_q,
    input logic [LW-1:0]  lfsr_q
);

    logic           acc;
    logic [AW-1:0]  hi_mask;
    logic [WAW-1:0] al_mask;

    assign acc = nxt_req && nxt_rdy;

    always_comb begin
        if (cfg_field_msb >= FIW'(AW - 1)) hi_mask = '0;
        else hi_mask = ~((AW'(1) << (cfg_field_msb + 1'b1)) - AW'(1));
        al_mask = (WAW'(1) << cfg_burst_log2) - WAW'(1);
    end

    // R3
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_start && !acc) |=> ($stable(addr_word_o) && $stable(cur_q)));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_start && acc && cfg_mode == MODE_SEQ) |=>
        (cur_q == AW'($past(cur_q) + $past(cfg_incr))));

    // R7
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start && cfg_mode == MODE_SEQ_RET) |=> (cur_q == $past(cfg_start_addr)));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_start && acc && cfg_mode == MODE_RSEQ && !phase_q) |=>
        ((cur_q & $past(hi_mask)) == ($past(cur_q) & $past(hi_mask))));

    // R9
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start || acc) |=> ((addr_word_o & $past(al_mask)) == '0));

    // R11
    restart_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_start |=> $stable(lfsr_q));

    // R10
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

bind mtag_addr_gen mtag_addr_gen_chk #(
    .AW(AW), .WAW(WAW), .LW(LW), .BLW(BLW), .FIW(FIW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start_addr(cfg_start_addr),
    .cfg_incr(cfg_incr), .cfg_field_msb(cfg_field_msb), .cfg_burst_log2(cfg_burst_log2),
    .nxt_req(nxt_req), .nxt_rdy(nxt_rdy), .loop_start(loop_start),
    .addr_word_o(addr_word_o), .cur_q(st_q.cur), .phase_q(st_q.phase), .lfsr_q(lfsr_q)
);

// File: tb/mtag_addr_gen_tb.sv
module mtag_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [30:0] cfg_start_addr = '0;
    logic [30:0] cfg_incr = '0;
    logic [4:0]  cfg_field_msb = '0;
    logic [2:0]  cfg_burst_log2 = '0;
    logic [31:0] cfg_seed = 32'h1234_5678;
    logic        nxt_req = 1'b0, nxt_rdy = 1'b0, loop_start = 1'b0;
    logic [25:0] addr_word_o;
    logic [30:0] addr_sym_o;

    int checks = 0;
    int fails  = 0;

    logic [30:0] m_cur;
    logic [31:0] m_lfsr;
    logic        m_phase, m_started;
    logic [25:0] m_word;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    mtag_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start_addr(cfg_start_addr),
        .cfg_incr(cfg_incr), .cfg_field_msb(cfg_field_msb), .cfg_burst_log2(cfg_burst_log2),
        .cfg_seed(cfg_seed), .nxt_req(nxt_req), .nxt_rdy(nxt_rdy), .loop_start(loop_start),
        .addr_word_o(addr_word_o), .addr_sym_o(addr_sym_o)
    );

    function automatic logic [31:0] lfsr_nx(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic logic [25:0] to_word(input logic [30:0] a, input logic [2:0] b);
        logic [25:0] m;
        m = (26'd1 << b) - 26'd1;
        return a[30:5] & ~m;
    endfunction

    task automatic model_reset();
        m_cur = '0; m_phase = 0; m_started = 0; m_word = '0;
        m_lfsr = (cfg_seed == 0) ? 32'h5EED_C0DE : cfg_seed;
    endtask

    task automatic model_step(input logic rq, input logic rd, input logic ls);
        logic [30:0] fm, sum;
        fm  = (cfg_field_msb >= 5'd30) ? '1 : ((31'd1 << (cfg_field_msb + 1)) - 31'd1);
        sum = m_cur + cfg_incr;
        if (ls) begin
            if (!m_started || cfg_mode == 2'd2) m_cur = cfg_start_addr;
            m_phase = 0; m_started = 1;
            m_word = to_word(m_cur, cfg_burst_log2);
        end else if (rq && rd) begin
            case (cfg_mode)
                2'd0, 2'd2: m_cur = sum;
                2'd1: begin m_cur = m_lfsr[30:0]; m_lfsr = lfsr_nx(m_lfsr); end
                default: begin
                    if (m_phase) begin
                        m_cur = (m_lfsr[30:0] & ~fm) | (sum & fm);
                        m_lfsr = lfsr_nx(m_lfsr);
                    end else m_cur = (m_cur & ~fm) | (sum & fm);
                    m_phase = ~m_phase;
                end
            endcase
            m_word = to_word(m_cur, cfg_burst_log2);
        end
    endtask

    // driver: one cycle of stimulus, expected word pushed to the scoreboard
    task automatic step(input logic rq, input logic rd, input logic ls, input string tag);
        @(negedge clk);
        nxt_req = rq; nxt_rdy = rd; loop_start = ls;
        @(posedge clk);
        model_step(rq, rd, ls);
        exp_q.push_back(m_word);
        tag_q.push_back(tag);
        #1;
        nxt_req = 0; nxt_rdy = 0; loop_start = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [25:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_word_o !== e || addr_sym_o !== {e, 5'b0}) begin
                fails++;
                $display("FAIL %s: word=%h sym=%h expected word=%h sym=%h",
                         t, addr_word_o, addr_sym_o, e, {e, 5'b0});
            end
        end
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        checks++;
        if (addr_word_o !== 0 || addr_sym_o !== 0) begin
            fails++;
            $display("FAIL R1 in reset: word=%h sym=%h expected 0", addr_word_o, addr_sym_o);
        end
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (addr_word_o !== 0 || addr_sym_o !== 0) begin
            fails++;
            $display("FAIL R1 after reset: word=%h sym=%h expected 0", addr_word_o, addr_sym_o);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // sequential, R2 / R7 / R8
        cfg_mode = 2'd0; cfg_start_addr = 31'h100; cfg_incr = 31'h40;
        step(0, 0, 1, "R7 first loop_start loads start");
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R2 sequential step / R8");
        // stalls, R3
        step(1, 0, 0, "R3 req without ready");
        step(0, 1, 0, "R3 ready without req");
        step(0, 0, 0, "R3 idle");
        step(1, 1, 0, "R2 step after stall");
        // second loop_start in mode 0 keeps address, R7
        step(0, 0, 1, "R7 no rewind in sequential mode");
        step(1, 1, 0, "R2 keeps advancing across loops");
        // rewind mode
        cfg_mode = 2'd2;
        step(1, 1, 0, "R2 rewind mode step");
        step(0, 0, 1, "R7 rewind to start");
        step(1, 1, 0, "R2 step after rewind");
        // alignment, R9
        cfg_burst_log2 = 3'd2; cfg_incr = 31'h20;
        for (int i = 0; i < 6; i++) step(1, 1, 0, "R9 burst alignment");
        cfg_incr = 31'h7FFF_FFE0;
        step(1, 1, 0, "R2 modulo wrap / R9");
        // random, R4
        cfg_mode = 2'd1; cfg_burst_log2 = 3'd0;
        for (int i = 0; i < 6; i++) step(1, 1, 0, "R4 random address from LFSR");
        step(1, 0, 0, "R3 random stall");
        // random-sequential, R5 R6 R11
        cfg_mode = 2'd3; cfg_field_msb = 5'd8; cfg_incr = 31'hC0;
        step(0, 0, 1, "R11 loop_start clears phase");
        for (int i = 0; i < 10; i++) step(1, 1, 0, "R5 R6 random-sequential");
        step(1, 1, 1, "R11 loop_start beats step");
        for (int i = 0; i < 6; i++) step(1, 1, 0, "R6 phase after restart");
        cfg_field_msb = 5'd30;
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R5 full-width field");

        // zero seed, R10
        cfg_seed = 32'h0; cfg_mode = 2'd1; cfg_field_msb = 5'd8;
        wait (exp_q.size() == 0);
        do_reset();
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R10 substitute seed");

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule